// File: doc/BRIEF.md
# Exclusive Two-Level Victim Cache Controller

This block keeps the tags and per-line state for a private pair of cache levels that never hold the same line. The first level is two-way set associative. The second level is sixteen-way set associative and is filled only with lines pushed down from the first level. A core lookup that hits the second level pulls the line up into the first level and invalidates it below. A lookup that misses both levels raises a request on the outer memory port. The returning fill is written straight into the first level and never into the second.

The controller accepts one lookup at a time. It answers each lookup with a level code once all line movement for that lookup is complete. Any valid first-level line displaced by an install drops into the second level. If the second-level set it lands in is full, the oldest line there leaves through a victim port with a valid/ready handshake. That line carries its address and its dirty flag. Set counts and the second-level way count are parameters. The block holds no line data.

Top module: `excl_cache_ctl`

## Requirements
- R1: A synchronous reset invalidates every way of both levels and returns all replacement state to its initial order. After reset `req_ready` is 1, `rsp_valid`, `fill_req_valid` and `vic_valid` are 0, and any lookup reports a miss.
- R2: Address bits [5:0] are the byte offset within a 64-byte line and do not affect lookup. The line address is `addr[ADDR_W-1:6]`. Each level selects its set from the low log2(sets) bits of the line address.
- R3: A lookup that hits the first level answers with `rsp_level` = 1. It raises no fill request and moves no line.
- R4: No line is ever valid in both levels at once. A lookup repeated right after a second-level hit answers with level 1.
- R5: A lookup that misses both levels holds `fill_req_valid` high with the line-aligned address until `fill_rsp_valid`. It then installs the line in the first level only and answers with `rsp_level` = 0.
- R6: First-level replacement in a set picks an invalid way 0 first, then an invalid way 1. If both ways are valid, it picks the way that was not the most recent to be hit or installed.
- R7: A valid first-level line displaced by an install is inserted into the second-level set selected by its own address.
- R8: A lookup that misses the first level and hits the second answers with `rsp_level` = 2. The line is invalidated in the second level and installed in the first.
- R9: Second-level insertion uses an invalid way if one exists. Otherwise it evicts the line inserted longest ago. The evicted line appears on `vic_valid` with its line-aligned `vic_addr`. The port holds steady until `vic_ready` is seen.
- R10: A store lookup marks its line dirty, whether it hits the first level or is installed there. The dirty flag stays with the line through every move and appears on `vic_dirty` at eviction.
- R11: Each accepted lookup produces exactly one `rsp_valid` pulse. `req_ready` stays low from acceptance through the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup request valid |
| req_store | input | 1 | Lookup is a store |
| req_addr | input | ADDR_W | Lookup byte address |
| req_ready | output | 1 | Controller can accept a lookup |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_level | output | 2 | 0 miss, 1 first-level hit, 2 second-level hit |
| fill_req_valid | output | 1 | Outer fill request pending |
| fill_req_addr | output | ADDR_W | Line-aligned address of the requested fill |
| fill_rsp_valid | input | 1 | Outer fill for the pending request has arrived |
| vic_valid | output | 1 | Evicted second-level line offered |
| vic_ready | input | 1 | Outer level takes the evicted line |
| vic_addr | output | ADDR_W | Line-aligned address of the evicted line |
| vic_dirty | output | 1 | Evicted line is dirty |

## Verification
The bench builds the block with four sets in each level, sixteen second-level ways and a 32-bit address. Because both levels share the same set count, a displaced line stays in the same set index. Eighteen lines in one set therefore fill both levels of that set, and the nineteenth forces a full-set eviction within a few dozen lookups. Random lookups over a pool of about twenty-four lines per set then repeatedly mix first-level hits, promotions, fills and evictions under random fill and victim-accept delays.

// File: rtl/excl_cache_pkg.sv
package excl_cache_pkg;

   localparam int LINE_OFS = 6;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOK,
      ST_FILL,
      ST_SPILL,
      ST_EVICT,
      ST_DONE
   } ctl_state_t;

   typedef enum logic [1:0] {
      LVL_MISS = 2'd0,
      LVL_L1   = 2'd1,
      LVL_L2   = 2'd2
   } hit_level_t;

endpackage

// File: rtl/excl_l1_array.sv
module excl_l1_array #(
   parameter int SETS  = 4,
   parameter int IDX_W = 2,
   parameter int TAG_W = 24
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] set_i,
   input  logic [TAG_W-1:0] tag_i,
   output logic             hit_o,
   output logic             hit_way_o,
   output logic             repl_way_o,
   output logic             repl_valid_o,
   output logic [TAG_W-1:0] repl_tag_o,
   output logic             repl_dirty_o,
   input  logic             touch_en_i,
   input  logic             touch_store_i,
   input  logic             fill_en_i,
   input  logic             fill_dirty_i
);
   localparam int WAYS = 2;

   logic [TAG_W-1:0] tag_q [SETS][WAYS];
   logic [WAYS-1:0]  vld_q [SETS];
   logic [WAYS-1:0]  dty_q [SETS];
   logic [SETS-1:0]  lru_q;
   logic [WAYS-1:0]  hit_vec;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = vld_q[set_i][w] && (tag_q[set_i][w] == tag_i);
   end

   assign hit_o     = |hit_vec;
   assign hit_way_o = hit_vec[1];

   always_comb begin
      if (!vld_q[set_i][0])      repl_way_o = 1'b0;
      else if (!vld_q[set_i][1]) repl_way_o = 1'b1;
      else                       repl_way_o = lru_q[set_i];
   end

   assign repl_valid_o = vld_q[set_i][repl_way_o];
   assign repl_tag_o   = tag_q[set_i][repl_way_o];
   assign repl_dirty_o = dty_q[set_i][repl_way_o];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < SETS; s++) begin
            vld_q[s] <= '0;
            dty_q[s] <= '0;
         end
         lru_q <= '0;
      end else begin
         if (touch_en_i) begin
            lru_q[set_i] <= ~hit_way_o;
            if (touch_store_i) dty_q[set_i][hit_way_o] <= 1'b1;
         end
         if (fill_en_i) begin
            tag_q[set_i][repl_way_o] <= tag_i;
            vld_q[set_i][repl_way_o] <= 1'b1;
            dty_q[set_i][repl_way_o] <= fill_dirty_i;
            lru_q[set_i]             <= ~repl_way_o;
         end
      end
   end

   // R4
   l1_hit_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(hit_vec));

   // R5
   l1_fill_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
      fill_en_i |-> !hit_o);

endmodule

// File: rtl/excl_age_pick.sv
module excl_age_pick #(
   parameter int WAYS  = 16,
   parameter int WAY_W = 4
) (
   input  logic [WAYS-1:0]       vld_i,
   input  logic [WAYS*WAY_W-1:0] age_i,
   output logic [WAY_W-1:0]      way_o
);
   always_comb begin
      way_o = '0;
      if (&vld_i) begin
         for (int w = 0; w < WAYS; w++)
            if (age_i[w*WAY_W +: WAY_W] == WAY_W'(WAYS-1)) way_o = WAY_W'(w);
      end else begin
         for (int w = WAYS-1; w >= 0; w--)
            if (!vld_i[w]) way_o = WAY_W'(w);
      end
   end
endmodule

// File: rtl/excl_l2_array.sv
module excl_l2_array #(
   parameter int SETS  = 4,
   parameter int IDX_W = 2,
   parameter int WAYS  = 16,
   parameter int WAY_W = 4,
   parameter int TAG_W = 24
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] lk_set_i,
   input  logic [TAG_W-1:0] lk_tag_i,
   output logic             hit_o,
   output logic             hit_dirty_o,
   input  logic             inv_en_i,
   input  logic [IDX_W-1:0] ins_set_i,
   input  logic [TAG_W-1:0] ins_tag_i,
   input  logic             ins_dirty_i,
   input  logic             ins_en_i,
   output logic             ev_valid_o,
   output logic [TAG_W-1:0] ev_tag_o,
   output logic             ev_dirty_o
);
   logic [TAG_W-1:0]       tag_q [SETS][WAYS];
   logic [WAY_W-1:0]       age_q [SETS][WAYS];
   logic [WAYS-1:0]        vld_q [SETS];
   logic [WAYS-1:0]        dty_q [SETS];
   logic [WAYS-1:0]        hit_vec;
   logic [WAYS-1:0]        dup_vec;
   logic [WAY_W-1:0]       hit_way;
   logic [WAY_W-1:0]       pick_way;
   logic [WAYS*WAY_W-1:0]  age_flat;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign hit_vec[w] = vld_q[lk_set_i][w] && (tag_q[lk_set_i][w] == lk_tag_i);
      assign dup_vec[w] = vld_q[ins_set_i][w] && (tag_q[ins_set_i][w] == ins_tag_i);
      assign age_flat[w*WAY_W +: WAY_W] = age_q[ins_set_i][w];
   end

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++)
         if (hit_vec[w]) hit_way = WAY_W'(w);
   end

   assign hit_o       = |hit_vec;
   assign hit_dirty_o = dty_q[lk_set_i][hit_way];

   excl_age_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) i_pick (
      .vld_i (vld_q[ins_set_i]),
      .age_i (age_flat),
      .way_o (pick_way)
   );

   assign ev_valid_o = vld_q[ins_set_i][pick_way];
   assign ev_tag_o   = tag_q[ins_set_i][pick_way];
   assign ev_dirty_o = dty_q[ins_set_i][pick_way];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < SETS; s++) begin
            vld_q[s] <= '0;
            dty_q[s] <= '0;
            for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
         end
      end else begin
         if (inv_en_i) vld_q[lk_set_i][hit_way] <= 1'b0;
         if (ins_en_i) begin
            tag_q[ins_set_i][pick_way] <= ins_tag_i;
            vld_q[ins_set_i][pick_way] <= 1'b1;
            dty_q[ins_set_i][pick_way] <= ins_dirty_i;
            for (int w = 0; w < WAYS; w++) begin
               if (WAY_W'(w) == pick_way)
                  age_q[ins_set_i][w] <= '0;
               else if (age_q[ins_set_i][w] < age_q[ins_set_i][pick_way])
                  age_q[ins_set_i][w] <= age_q[ins_set_i][w] + 1'b1;
            end
         end
      end
   end

   // R4
   l2_hit_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(hit_vec));

   // R7
   l2_no_dup_chk: assert property (@(posedge clk) disable iff (rst)
      ins_en_i |-> !(|dup_vec));

   // R8
   l2_inv_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
      inv_en_i |-> hit_o);

endmodule

// File: rtl/excl_cache_ctl.sv
module excl_cache_ctl
   import excl_cache_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int L1_SETS = 4,
   parameter int L2_SETS = 4,
   parameter int L2_WAYS = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_store,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [1:0]        rsp_level,
   output logic              fill_req_valid,
   output logic [ADDR_W-1:0] fill_req_addr,
   input  logic              fill_rsp_valid,
   output logic              vic_valid,
   input  logic              vic_ready,
   output logic [ADDR_W-1:0] vic_addr,
   output logic              vic_dirty
);
   localparam int OFS    = LINE_OFS;
   localparam int LINE_W = ADDR_W - OFS;
   localparam int L1_IDX = $clog2(L1_SETS);
   localparam int L2_IDX = $clog2(L2_SETS);
   localparam int L1_TAG = LINE_W - L1_IDX;
   localparam int L2_TAG = LINE_W - L2_IDX;
   localparam int WAY_W  = $clog2(L2_WAYS);

   if (L1_SETS < 2 || (L1_SETS & (L1_SETS - 1)) != 0) begin : g_bad_l1_sets
      $error("L1_SETS must be a power of two of at least 2");
   end
   if (L2_SETS < 2 || (L2_SETS & (L2_SETS - 1)) != 0) begin : g_bad_l2_sets
      $error("L2_SETS must be a power of two of at least 2");
   end
   if (L2_WAYS < 2 || (L2_WAYS & (L2_WAYS - 1)) != 0) begin : g_bad_l2_ways
      $error("L2_WAYS must be a power of two of at least 2");
   end
   if (L1_TAG < 1 || L2_TAG < 1) begin : g_bad_addr
      $error("ADDR_W too small for the set counts");
   end

   ctl_state_t        state_q;
   hit_level_t        lvl_q;
   logic [LINE_W-1:0] line_q;
   logic              store_q;
   logic [LINE_W-1:0] spill_line_q;
   logic              spill_dirty_q;
   logic [LINE_W-1:0] vic_line_q;
   logic              vic_dirty_q;

   logic              l1_hit, l1_hit_way, l1_repl_way, l1_repl_valid, l1_repl_dirty;
   logic [L1_TAG-1:0] l1_repl_tag;
   logic [LINE_W-1:0] l1_repl_line;
   logic              l2_hit, l2_hit_dirty, l2_ev_valid, l2_ev_dirty;
   logic [L2_TAG-1:0] l2_ev_tag;
   logic              l1_touch, l2_inv, l1_fill, l1_fill_dirty, l2_ins;

   assign l1_repl_line = {l1_repl_tag, line_q[L1_IDX-1:0]};

   always_comb begin
      l1_touch      = (state_q == ST_LOOK) && l1_hit;
      l2_inv        = (state_q == ST_LOOK) && !l1_hit && l2_hit;
      l1_fill       = l2_inv || ((state_q == ST_FILL) && fill_rsp_valid);
      l1_fill_dirty = l2_inv ? (l2_hit_dirty | store_q) : store_q;
      l2_ins        = (state_q == ST_SPILL);
   end

   excl_l1_array #(.SETS(L1_SETS), .IDX_W(L1_IDX), .TAG_W(L1_TAG)) i_l1 (
      .clk           (clk),
      .rst           (rst),
      .set_i         (line_q[L1_IDX-1:0]),
      .tag_i         (line_q[LINE_W-1:L1_IDX]),
      .hit_o         (l1_hit),
      .hit_way_o     (l1_hit_way),
      .repl_way_o    (l1_repl_way),
      .repl_valid_o  (l1_repl_valid),
      .repl_tag_o    (l1_repl_tag),
      .repl_dirty_o  (l1_repl_dirty),
      .touch_en_i    (l1_touch),
      .touch_store_i (store_q),
      .fill_en_i     (l1_fill),
      .fill_dirty_i  (l1_fill_dirty)
   );

   excl_l2_array #(.SETS(L2_SETS), .IDX_W(L2_IDX), .WAYS(L2_WAYS), .WAY_W(WAY_W),
                   .TAG_W(L2_TAG)) i_l2 (
      .clk         (clk),
      .rst         (rst),
      .lk_set_i    (line_q[L2_IDX-1:0]),
      .lk_tag_i    (line_q[LINE_W-1:L2_IDX]),
      .hit_o       (l2_hit),
      .hit_dirty_o (l2_hit_dirty),
      .inv_en_i    (l2_inv),
      .ins_set_i   (spill_line_q[L2_IDX-1:0]),
      .ins_tag_i   (spill_line_q[LINE_W-1:L2_IDX]),
      .ins_dirty_i (spill_dirty_q),
      .ins_en_i    (l2_ins),
      .ev_valid_o  (l2_ev_valid),
      .ev_tag_o    (l2_ev_tag),
      .ev_dirty_o  (l2_ev_dirty)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q       <= ST_IDLE;
         lvl_q         <= LVL_MISS;
         line_q        <= '0;
         store_q       <= 1'b0;
         spill_line_q  <= '0;
         spill_dirty_q <= 1'b0;
         vic_line_q    <= '0;
         vic_dirty_q   <= 1'b0;
      end else begin
         if (l1_fill && l1_repl_valid) begin
            spill_line_q  <= l1_repl_line;
            spill_dirty_q <= l1_repl_dirty;
         end
         case (state_q)
            ST_IDLE: if (req_valid) begin
               line_q  <= req_addr[ADDR_W-1:OFS];
               store_q <= req_store;
               state_q <= ST_LOOK;
            end
            ST_LOOK: begin
               if (l1_hit) begin
                  lvl_q   <= LVL_L1;
                  state_q <= ST_DONE;
               end else if (l2_hit) begin
                  lvl_q   <= LVL_L2;
                  state_q <= l1_repl_valid ? ST_SPILL : ST_DONE;
               end else begin
                  lvl_q   <= LVL_MISS;
                  state_q <= ST_FILL;
               end
            end
            ST_FILL: if (fill_rsp_valid)
               state_q <= l1_repl_valid ? ST_SPILL : ST_DONE;
            ST_SPILL: begin
               if (l2_ev_valid) begin
                  vic_line_q  <= {l2_ev_tag, spill_line_q[L2_IDX-1:0]};
                  vic_dirty_q <= l2_ev_dirty;
                  state_q     <= ST_EVICT;
               end else begin
                  state_q <= ST_DONE;
               end
            end
            ST_EVICT: if (vic_ready) state_q <= ST_DONE;
            ST_DONE:  state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready      = (state_q == ST_IDLE);
   assign rsp_valid      = (state_q == ST_DONE);
   assign rsp_level      = lvl_q;
   assign fill_req_valid = (state_q == ST_FILL);
   assign fill_req_addr  = {line_q, {OFS{1'b0}}};
   assign vic_valid      = (state_q == ST_EVICT);
   assign vic_addr       = {vic_line_q, {OFS{1'b0}}};
   assign vic_dirty      = vic_dirty_q;

   // R4
   exclusive_levels_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_LOOK) |-> !(l1_hit && l2_hit));

   // R5
   fill_hold_chk: assert property (@(posedge clk) disable iff (rst)
      fill_req_valid && !fill_rsp_valid |=> fill_req_valid && $stable(fill_req_addr));

   // R9
   vic_hold_chk: assert property (@(posedge clk) disable iff (rst)
      vic_valid && !vic_ready |=> vic_valid && $stable(vic_addr) && $stable(vic_dirty));

   // R11
   rsp_single_chk: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |=> !rsp_valid && req_ready);

   // R1
   reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> req_ready && !rsp_valid && !vic_valid && !fill_req_valid);

endmodule

// File: tb/test_excl_cache_ctl.sv
module test_excl_cache_ctl;
   localparam int AW  = 32;
   localparam int L1S = 4;
   localparam int L2S = 4;
   localparam int W2  = 16;
   localparam int LW  = AW - 6;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req_valid = 1'b0, req_store = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          req_ready, rsp_valid;
   logic [1:0]    rsp_level;
   logic          fill_req_valid;
   logic [AW-1:0] fill_req_addr;
   logic          fill_rsp_valid = 1'b0;
   logic          vic_valid;
   logic          vic_ready = 1'b0;
   logic [AW-1:0] vic_addr;
   logic          vic_dirty;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   excl_cache_ctl #(.ADDR_W(AW), .L1_SETS(L1S), .L2_SETS(L2S), .L2_WAYS(W2)) i_excl_cache_ctl (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store), .req_addr(req_addr),
      .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_level(rsp_level),
      .fill_req_valid(fill_req_valid), .fill_req_addr(fill_req_addr),
      .fill_rsp_valid(fill_rsp_valid), .vic_valid(vic_valid), .vic_ready(vic_ready),
      .vic_addr(vic_addr), .vic_dirty(vic_dirty)
   );

   // reference model built from the requirements
   logic [LW-1:0] m1_line [L1S][2];
   bit            m1_v    [L1S][2];
   bit            m1_d    [L1S][2];
   bit            m1_lru  [L1S];
   logic [LW-1:0] m2_line [L2S][W2];
   bit            m2_d    [L2S][W2];
   int            m2_n    [L2S];

   function automatic void model_reset();
      for (int s = 0; s < L1S; s++) begin
         m1_v[s][0] = 0; m1_v[s][1] = 0; m1_d[s][0] = 0; m1_d[s][1] = 0; m1_lru[s] = 0;
      end
      for (int s = 0; s < L2S; s++) m2_n[s] = 0;
   endfunction

   function automatic void model_access(input logic [LW-1:0] ln, input bit st,
                                        output int lvl, output bit ev,
                                        output logic [LW-1:0] ev_ln, output bit ev_d);
      int s1, s2, pos, w, vs;
      bit d, vd;
      logic [LW-1:0] vl;
      s1 = int'(ln % L1S);
      s2 = int'(ln % L2S);
      ev = 0; ev_ln = '0; ev_d = 0;
      for (int k = 0; k < 2; k++)
         if (m1_v[s1][k] && m1_line[s1][k] == ln) begin
            lvl = 1;
            if (st) m1_d[s1][k] = 1;
            m1_lru[s1] = (k == 0);
            return;
         end
      pos = -1;
      for (int k = 0; k < m2_n[s2]; k++) if (m2_line[s2][k] == ln) pos = k;
      if (pos >= 0) begin
         lvl = 2;
         d = m2_d[s2][pos] | st;
         for (int k = pos; k < m2_n[s2] - 1; k++) begin
            m2_line[s2][k] = m2_line[s2][k+1];
            m2_d[s2][k]    = m2_d[s2][k+1];
         end
         m2_n[s2]--;
      end else begin
         lvl = 0;
         d = st;
      end
      if (!m1_v[s1][0])      w = 0;
      else if (!m1_v[s1][1]) w = 1;
      else                   w = m1_lru[s1] ? 1 : 0;
      if (m1_v[s1][w]) begin
         vl = m1_line[s1][w];
         vd = m1_d[s1][w];
         vs = int'(vl % L2S);
         if (m2_n[vs] == W2) begin
            ev = 1; ev_ln = m2_line[vs][W2-1]; ev_d = m2_d[vs][W2-1];
            m2_n[vs]--;
         end
         for (int k = m2_n[vs]; k > 0; k--) begin
            m2_line[vs][k] = m2_line[vs][k-1];
            m2_d[vs][k]    = m2_d[vs][k-1];
         end
         m2_line[vs][0] = vl;
         m2_d[vs][0]    = vd;
         m2_n[vs]++;
      end
      m1_line[s1][w] = ln;
      m1_v[s1][w]    = 1;
      m1_d[s1][w]    = d;
      m1_lru[s1]     = (w == 0);
   endfunction

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      model_reset();
      @(negedge clk);
      // R1: idle outputs after reset
      check(req_ready && !rsp_valid && !fill_req_valid && !vic_valid, "R1", "idle after reset",
            {req_ready, rsp_valid, fill_req_valid, vic_valid}, 4'b1000);
   endtask

   task automatic run_req(input logic [LW-1:0] ln, input logic [5:0] ofs, input bit st,
                          input string tag);
      int lvl;
      bit ev, ev_d;
      logic [LW-1:0] ev_ln;
      bit done, seen_fill, seen_vic;
      string rq;
      done = 0; seen_fill = 0; seen_vic = 0;
      model_access(ln, st, lvl, ev, ev_ln, ev_d);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_addr = {ln, ofs}; req_store = st;
      @(negedge clk);
      req_valid = 1'b0; req_store = 1'b0;
      for (int cyc = 0; cyc < 400 && !done; cyc++) begin
         fill_rsp_valid = 1'b0;
         vic_ready      = 1'b0;
         if (fill_req_valid) begin
            if (!seen_fill)
               check(fill_req_addr == {ln, 6'b0}, "R5", "fill address", fill_req_addr, {ln, 6'b0});
            seen_fill = 1;
            if ($urandom_range(2) == 0) fill_rsp_valid = 1'b1;
         end
         if (vic_valid) begin
            if (!seen_vic) begin
               check(ev && vic_addr == {ev_ln, 6'b0}, "R9", "victim address", vic_addr, {ev_ln, 6'b0});
               check(vic_dirty == ev_d, "R10", "victim dirty", vic_dirty, ev_d);
            end
            seen_vic = 1;
            if ($urandom_range(1) == 1) vic_ready = 1'b1;
         end
         if (rsp_valid) begin
            if (tag != "") rq = tag;
            else if (lvl == 1) rq = "R3";
            else if (lvl == 2) rq = "R8";
            else rq = "R5";
            check(rsp_level == 2'(lvl), rq, "hit level", rsp_level, lvl);
            check(!req_ready, "R11", "busy during response", req_ready, 0);
            done = 1;
         end else begin
            @(negedge clk);
         end
      end
      fill_rsp_valid = 1'b0;
      vic_ready      = 1'b0;
      check(done, "R11", "response seen", done, 1);
      check(seen_fill == (lvl == 0), "R5", "fill request only on miss", seen_fill, lvl == 0);
      check(seen_vic == ev, "R9", "eviction presence", seen_vic, ev);
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R11 watchdog expired: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED));
      do_reset();

      // directed: set 1 lines are 1, 5, 9, ...
      run_req(26'd1, 6'h00, 1'b0, "R1");      // cold miss
      run_req(26'd1, 6'h3F, 1'b0, "R2");      // offset ignored, first-level hit
      run_req(26'd1, 6'h10, 1'b1, "R3");      // store hit, line now dirty
      run_req(26'd5, 6'h00, 1'b0, "");        // second way
      run_req(26'd9, 6'h00, 1'b0, "R6");      // replaces the line not used last (line 1)
      run_req(26'd5, 6'h04, 1'b0, "R6");      // line 5 survived
      run_req(26'd1, 6'h00, 1'b0, "R7");      // line 1 found in second level
      run_req(26'd1, 6'h00, 1'b0, "R4");      // now only in first level

      // fill set 2 past both levels, stores on even lines
      for (int k = 0; k < 22; k++)
         run_req(26'(2 + 4*k), 6'(k), (k % 2) == 0, "");
      run_req(26'd6, 6'h00, 1'b0, "R9");      // oldest survivor order
      run_req(26'd10, 6'h00, 1'b0, "R10");

      // random mix
      for (int n = 0; n < 400; n++)
         run_req(26'($urandom_range(3) + 4*$urandom_range(23)), 6'($urandom_range(63)),
                 1'($urandom_range(1)), "");

      // reset clears contents
      do_reset();
      run_req(26'd1, 6'h00, 1'b0, "R1");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule